// File: doc/BRIEF.md
# Clos Middle-Stage Router by Euler Splitting

This block chooses, for every connection of a three-stage Clos fabric with as many middle switches as each outer switch has ports, the middle switch that carries it. A pulse on `start` captures one destination output per input port, plus a mask that says which inputs really carry traffic. Each connection is treated as an edge between the first-stage switch that holds its input and the third-stage switch that holds its output. This gives a bipartite multigraph in which every switch is a vertex.

Inputs without traffic are first tied to outputs that are still free, so every vertex ends up with the same degree. The graph is then halved a number of times equal to the base-2 log of that degree. In each halving the block walks closed trails of edges that are not yet placed and alternates each edge between two halves. Each halving decides one bit of the middle-switch index, most significant bit first. After the last halving every class has degree one, so the index is a legal color. A final pass compares every pair of connections and flags any switch that has two edges of the same color. `done` then rises and holds the result until the next start.

Top module: `clos_edge_colorer`

## Requirements
- R1: After reset `busy`, `done`, `conflict` and every bit of `mid_sel` are 0.
- R2: A `start` pulse while idle captures `dest` and `req_valid`, raises `busy` on the next cycle and clears `done`; `busy` and `done` are never both high.
- R3: Connection i joins first-stage switch i / N_PORT and third-stage switch dest_i / N_PORT. dest_i is the field `dest[i*PW +: PW]` and its middle switch is the field `mid_sel[i*CW +: CW]`, with PW = log2(M*N_PORT) and CW = log2(N_PORT).
- R4: No two valid connections whose inputs share a first-stage switch get the same middle switch.
- R5: No two valid connections whose outputs share a third-stage switch get the same middle switch.
- R6: Every full permutation (all `req_valid` bits set) is routed with `conflict` low.
- R7: For a partial permutation, each invalid input is tied to a free output before coloring, so the valid connections still satisfy R4 and R5. The `dest` value of an invalid input has no effect.
- R8: `done` rises at most NC + 2*NC*CW + 4 cycles after the `start` edge, with NC = M*N_PORT.
- R9: Once `done` is high it stays high and `mid_sel` stays unchanged until the next `start`. A `start` while `busy` is ignored and the job in progress keeps its captured inputs.
- R10: `conflict`, valid with `done`, is high only if some switch has two edges of the same color. It stays low for any legal request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the request and begin routing |
| dest | input | M*N_PORT*PW | Destination output per input port |
| req_valid | input | M*N_PORT | Input carries a connection |
| busy | output | 1 | Routing in progress |
| done | output | 1 | Result ready and held |
| conflict | output | 1 | Final check found a color clash |
| mid_sel | output | M*N_PORT*CW | Middle-switch index per connection |

## Verification
On every cycle, assertions check that busy and done exclude each other, that an idle start leads to busy, that padding leaves no output free, that the trail walk never revisits an edge already placed in the current halving, and that a finished result holds still. Whether the colors are proper at both stages, whether invalid inputs are left out of the result, whether an input pattern reaches the latency bound, and whether a start during a job is ignored can only be shown by the bench. It runs identity, transposed, strided, reversed and partial requests and checks each result against the switch grouping it works out itself.

// File: rtl/clos_edge_colorer.sv
module clos_edge_colorer #(
  parameter int M      = 4,
  parameter int N_PORT = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start,
  input  logic [M*N_PORT*$clog2(M*N_PORT)-1:0]        dest,
  input  logic [M*N_PORT-1:0]                         req_valid,
  output logic                                        busy,
  output logic                                        done,
  output logic                                        conflict,
  output logic [M*N_PORT*$clog2(N_PORT)-1:0]          mid_sel
);
  localparam int NC = M * N_PORT;
  localparam int PW = $clog2(NC);
  localparam int CW = $clog2(N_PORT);
  localparam int RW = $clog2(CW + 1);

  typedef enum logic [1:0] {S_IDLE, S_PAD, S_SPLIT, S_CHK} st_t;
  st_t st;

  logic [PW-1:0] dst_r [NC];
  logic [CW-1:0] col_r [NC];
  logic [NC-1:0] valid_r, used_r, mark_r, in_used;
  logic [PW-1:0] idx_r, cur_r;
  logic [RW-1:0] rnd_r;
  logic          active_r, bit_r, side_r;

  logic          free_found, start_found, nxt_found, conf_c;
  logic [PW-1:0] free_idx, start_idx, nxt_idx;
  logic [CW-1:0] cmask, bsel;

  assign busy  = (st != S_IDLE);
  assign cmask = ~({CW{1'b1}} >> rnd_r);
  assign bsel  = CW'(1) << (CW - 1 - int'(rnd_r));

  always_comb begin
    in_used = '0;
    for (int e = 0; e < NC; e++)
      if (req_valid[e]) in_used[dest[e*PW +: PW]] = 1'b1;
  end

  always_comb begin
    free_found = 1'b0; free_idx = '0;
    start_found = 1'b0; start_idx = '0;
    nxt_found = 1'b0; nxt_idx = '0;
    for (int f = NC - 1; f >= 0; f--) begin
      if (!used_r[f]) begin free_found = 1'b1; free_idx = PW'(f); end
      if (!mark_r[f]) begin start_found = 1'b1; start_idx = PW'(f); end
      if (!mark_r[f] && PW'(f) != cur_r &&
          ((col_r[f] ^ col_r[cur_r]) & cmask) == '0 &&
          (side_r ? (dst_r[f] >> CW) == (dst_r[cur_r] >> CW)
                  : (f / N_PORT) == (int'(cur_r) / N_PORT))) begin
        nxt_found = 1'b1; nxt_idx = PW'(f);
      end
    end
  end

  always_comb begin
    conf_c = 1'b0;
    for (int a = 0; a < NC; a++)
      for (int b = a + 1; b < NC; b++)
        if (col_r[a] == col_r[b] &&
            ((a / N_PORT) == (b / N_PORT) || (dst_r[a] >> CW) == (dst_r[b] >> CW)))
          conf_c = 1'b1;
  end

  for (genvar g = 0; g < NC; g++) begin : g_out
    assign mid_sel[g*CW +: CW] = col_r[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int e = 0; e < NC; e++) begin dst_r[e] <= '0; col_r[e] <= '0; end
      valid_r <= '0; used_r <= '0; mark_r <= '0;
      idx_r <= '0; cur_r <= '0; rnd_r <= '0;
      active_r <= 1'b0; bit_r <= 1'b0; side_r <= 1'b0;
      done <= 1'b0; conflict <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          for (int e = 0; e < NC; e++) begin
            dst_r[e] <= dest[e*PW +: PW];
            col_r[e] <= '0;
          end
          valid_r <= req_valid; used_r <= in_used; mark_r <= '0;
          idx_r <= '0; rnd_r <= '0; active_r <= 1'b0;
          done <= 1'b0; conflict <= 1'b0;
          st <= S_PAD;
        end
        S_PAD: begin
          if (!valid_r[idx_r] && free_found) begin
            dst_r[idx_r] <= free_idx;
            used_r[free_idx] <= 1'b1;
          end
          idx_r <= idx_r + 1'b1;
          if (idx_r == PW'(NC - 1)) st <= S_SPLIT;
        end
        S_SPLIT: begin
          if (!active_r) begin
            if (start_found) begin
              cur_r <= start_idx; bit_r <= 1'b0; side_r <= 1'b1; active_r <= 1'b1;
            end else begin
              mark_r <= '0;
              if (rnd_r == RW'(CW - 1)) st <= S_CHK;
              else rnd_r <= rnd_r + 1'b1;
            end
          end else begin
            mark_r[cur_r] <= 1'b1;
            col_r[cur_r]  <= (col_r[cur_r] & ~bsel) | (bit_r ? bsel : '0);
            if (nxt_found) begin
              cur_r <= nxt_idx; bit_r <= ~bit_r; side_r <= ~side_r;
            end else begin
              active_r <= 1'b0;
            end
          end
        end
        S_CHK: begin
          conflict <= conf_c;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  assert_pad_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPLIT) |-> (&used_r));
  assert_walk_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPLIT && active_r) |-> !mark_r[cur_r]);
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(mid_sel)));
  assert_clean_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !conflict);
endmodule

// File: tb/sim_clos_edge_colorer.sv
module sim_clos_edge_colorer;
  localparam int M = 4, NP = 4, NC = M * NP, PW = 4, CW = 2;
  localparam int BOUND = NC + 2 * NC * CW + 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NC*PW-1:0] dest = '0;
  logic [NC-1:0] req_valid = '0;
  logic busy, done, conflict;
  logic [NC*CW-1:0] mid_sel;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int d [NC];
  logic [NC-1:0] v;

  clos_edge_colorer #(.M(M), .N_PORT(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dest(dest), .req_valid(req_valid),
    .busy(busy), .done(done), .conflict(conflict), .mid_sel(mid_sel));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int col(input int e);
    return int'(mid_sel[e*CW +: CW]);
  endfunction

  task automatic load();
    for (int e = 0; e < NC; e++) dest[e*PW +: PW] = PW'(d[e]);
    req_valid = v;
  endtask

  task automatic verify(input string tag);
    int bad_in = 0, bad_out = 0;
    for (int a = 0; a < NC; a++)
      for (int b = a + 1; b < NC; b++)
        if (v[a] && v[b] && col(a) == col(b)) begin
          if (a / NP == b / NP) bad_in++;
          if (d[a] / NP == d[b] / NP) bad_out++;
        end
    chk(bad_in == 0, {"R4 first-stage clash ", tag}, bad_in, 0);
    chk(bad_out == 0, {"R5 third-stage clash ", tag}, bad_out, 0);
    chk(conflict == 1'b0, {"R10 conflict flag ", tag}, int'(conflict), 0);
  endtask

  task automatic run(input string tag);
    int cyc = 0;
    load();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, {"R2 busy after start ", tag}, int'(busy), 1);
    cyc = 1;
    while (!done && cyc < BOUND + 10) begin @(negedge clk); cyc++; end
    chk(done && cyc <= BOUND, {"R8 latency ", tag}, cyc, BOUND);
    verify(tag);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !conflict && mid_sel == '0, "R1 reset state", int'(mid_sel), 0);
  endtask

  task automatic t_identity();
    for (int e = 0; e < NC; e++) d[e] = e;
    v = '1; run("identity R6");
  endtask

  task automatic t_transpose();
    for (int e = 0; e < NC; e++) d[e] = (e % NP) * NP + e / NP;
    v = '1; run("transpose R3");
  endtask

  task automatic t_stride();
    for (int e = 0; e < NC; e++) d[e] = (5 * e + 3) % NC;
    v = '1; run("stride R6");
  endtask

  task automatic t_reverse();
    for (int e = 0; e < NC; e++) d[e] = NC - 1 - e;
    v = '1; run("reverse R6");
  endtask

  task automatic t_partial();
    for (int e = 0; e < NC; e++) begin
      v[e] = (e % 2 == 0);
      d[e] = v[e] ? (3 * e) % NC : 0;
    end
    run("partial R7");
  endtask

  task automatic t_hold_and_ignore();
    logic [NC*CW-1:0] snap;
    bit stable = 1;
    for (int e = 0; e < NC; e++) d[e] = (7 * e + 1) % NC;
    v = '1;
    load();
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    for (int e = 0; e < NC; e++) dest[e*PW +: PW] = PW'(e);
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < BOUND + 10 && !done; c++) @(negedge clk);
    chk(done == 1'b1, "R9 done after ignored start", int'(done), 1);
    verify("busy start ignored R9");
    snap = mid_sel;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (!done || mid_sel != snap) stable = 0;
    end
    chk(stable, "R9 result held", int'(stable), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_identity();
    t_transpose();
    t_stride();
    t_reverse();
    t_partial();
    t_hold_and_ignore();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule